// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block decides, clock by clock, whether the high-side and low-side switch gates of a synchronous buck power stage may be driven. It takes a decoded PWM level with a separate idle (tristate) flag, a drive-enable input, a supply-good bit and a synchronous-rectification enable, together with three digital comparator results: low-side gate discharged, switch node fallen, and high-side gate-source voltage discharged. It produces one enable per gate.

Every handover from one switch to the other goes through a wait state. A gate turns on only after the comparator for the opposite switch reports that switch is off, and a programmable dead time has passed. If the switch node never falls, a longer fallback count starts once the high-side gate is sensed off and ends in a low-side turn-on, so the bootstrap capacitor still recharges. The drive-enable, supply-good and idle flag force both gates off. Clearing the synchronous-rectification enable keeps the low side off so the stage runs as a diode-emulating converter at light load. The dead times and the fallback count are parameters in clock cycles. The fallback count must be larger than the switch-node dead time.

Top module: `deadtime_gate_seq`

## Requirements
- R1: While rst_n is low, hs_en and ls_en are both 0.
- R2: hs_en and ls_en are never 1 in the same cycle.
- R3: When pwm_cmd goes to 1 with ls_en on, ls_en falls at the next clock edge. hs_en stays 0 until ls_gate_low has been 1 for DEAD_ON_CYC consecutive edges, and rises on the last of them.
- R4: When pwm_cmd goes to 0 with hs_en on, hs_en falls at the next clock edge. ls_en rises once sw_node_low has been 1 for DEAD_OFF_CYC consecutive edges.
- R5: If sw_node_low stays 0 after the high side turns off, ls_en rises once hs_gate_low has been 1 for TIMEOUT_CYC consecutive edges. TIMEOUT_CYC must exceed DEAD_OFF_CYC.
- R6: drive_en = 0 forces both enables to 0 from the next clock edge, whatever pwm_cmd is.
- R7: supply_ok = 0 forces both enables to 0 from the next clock edge, whatever pwm_cmd is.
- R8: pwm_tri = 1 forces both enables to 0 from the next clock edge. On leaving the idle state with pwm_cmd = 0 and hs_gate_low = 1, ls_en rises at the next edge. On leaving it with pwm_cmd = 1, hs_en rises after the R3 dead-on sequence.
- R9: sync_mode = 0 holds ls_en at 0 from the next clock edge, while hs_en still follows pwm_cmd with the R3 sequence.
- R10: When sync_mode returns to 1 while pwm_cmd = 0, hs_en = 0 and hs_gate_low = 1, ls_en rises at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_cmd | input | 1 | Decoded PWM level: 1 = high side wanted |
| pwm_tri | input | 1 | PWM input is in its idle window: both gates off |
| drive_en | input | 1 | 0 disables both gates |
| supply_ok | input | 1 | Supply above lockout threshold (hysteresis applied upstream) |
| sync_mode | input | 1 | 1 = low side complements PWM; 0 = low side held off |
| ls_gate_low | input | 1 | Low-side gate sensed below its threshold |
| sw_node_low | input | 1 | Switch node sensed below its threshold |
| hs_gate_low | input | 1 | High-side gate-source voltage sensed below its threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
A wrong sequencer state shows at the ports within one clock edge, because both enables decode the state register directly. A state stuck in a wait phase holds both enables low past the expected rise edge. A skipped wait phase raises a gate at the very edge where the opposite one falls. An off-by-one dead-time counter moves the rising edge of an enable by exactly one cycle. The bench therefore checks each enable one cycle before and at its expected rise. A missing fallback path shows as ls_en never rising while the switch-node sense stays low.

// File: rtl/gate_seq_pkg.sv
// Shared types for the gate sequencer.
// Assumes nothing beyond SystemVerilog 2017 enums.
package gate_seq_pkg;

    // Sequencer phases; each gate enable decodes from one phase only.
    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_LS_ON       = 3'd1,
        ST_WAIT_LS_LOW = 3'd2,
        ST_HS_ON       = 3'd3,
        ST_WAIT_SW_LOW = 3'd4
    } seq_state_t;

    // Index of each qualified delay counter.
    localparam int unsigned DLY_DEAD_ON  = 0;
    localparam int unsigned DLY_DEAD_OFF = 1;
    localparam int unsigned DLY_TIMEOUT  = 2;
    localparam int unsigned DLY_COUNT    = 3;

endpackage

// File: rtl/sense_delay.sv
// Counts consecutive cycles in which a sense input is high while armed.
// done is high in the cycle in which the LIMIT-th consecutive sample is seen.
// Assumes the sense input is already synchronous to clk and that LIMIT >= 1.
module sense_delay #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sense,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Completion when armed, sensed, and the count has reached the last step.
    always_comb begin
        done = arm && sense && (cnt == LAST);
    end

    // Count qualified samples; any gap or disarm restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !sense) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cmd_decode.sv
// Reduces the control inputs to the three requests the sequencer acts on.
// Assumes all inputs are synchronous to the sequencer clock.
module cmd_decode (
    input  logic pwm_cmd,
    input  logic pwm_tri,
    input  logic drive_en,
    input  logic supply_ok,
    input  logic sync_mode,
    output logic run,
    output logic want_hs,
    output logic want_ls
);
    // run is false for disable, lockout or idle; wants are only valid with run.
    always_comb begin
        run     = drive_en && supply_ok && !pwm_tri;
        want_hs = run && pwm_cmd;
        want_ls = run && !pwm_cmd && sync_mode;
    end
endmodule

// File: rtl/deadtime_gate_seq.sv
// Gate-enable sequencer for a synchronous buck stage.
// Each enable is decoded from a registered phase, so the two enables can
// never overlap. Every turn-on waits for the opposite switch to be sensed
// off plus a dead time. A fallback count on the high-side gate sense forces
// the low-side turn-on if the switch node never falls.
// Assumes sense inputs are synchronised upstream and that
// TIMEOUT_CYC > DEAD_OFF_CYC >= 1 and DEAD_ON_CYC >= 1.
module deadtime_gate_seq
    import gate_seq_pkg::*;
#(
    parameter int unsigned DEAD_ON_CYC  = 2,
    parameter int unsigned DEAD_OFF_CYC = 3,
    parameter int unsigned TIMEOUT_CYC  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic pwm_tri,
    input  logic drive_en,
    input  logic supply_ok,
    input  logic sync_mode,
    input  logic ls_gate_low,
    input  logic sw_node_low,
    input  logic hs_gate_low,
    output logic hs_en,
    output logic ls_en
);
    localparam int unsigned LIMITS [DLY_COUNT] = '{DEAD_ON_CYC, DEAD_OFF_CYC, TIMEOUT_CYC};

    seq_state_t state, state_nx;
    logic run, want_hs, want_ls;
    logic [DLY_COUNT-1:0] dly_arm, dly_sense, dly_done;

    cmd_decode i_cmd (
        .pwm_cmd   (pwm_cmd),
        .pwm_tri   (pwm_tri),
        .drive_en  (drive_en),
        .supply_ok (supply_ok),
        .sync_mode (sync_mode),
        .run       (run),
        .want_hs   (want_hs),
        .want_ls   (want_ls)
    );

    // Route each delay counter to the phase that arms it and its sense input.
    always_comb begin
        dly_arm[DLY_DEAD_ON]    = (state == ST_WAIT_LS_LOW);
        dly_sense[DLY_DEAD_ON]  = ls_gate_low;
        dly_arm[DLY_DEAD_OFF]   = (state == ST_WAIT_SW_LOW);
        dly_sense[DLY_DEAD_OFF] = sw_node_low;
        dly_arm[DLY_TIMEOUT]    = (state == ST_WAIT_SW_LOW);
        dly_sense[DLY_TIMEOUT]  = hs_gate_low;
    end

    for (genvar g = 0; g < DLY_COUNT; g++) begin : g_dly
        sense_delay #(.LIMIT(LIMITS[g])) i_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (dly_arm[g]),
            .sense (dly_sense[g]),
            .done  (dly_done[g])
        );
    end

    // Next phase: forced off first, then the handover rules of each phase.
    always_comb begin
        state_nx = state;
        if (!run) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (want_hs)                      state_nx = ST_WAIT_LS_LOW;
                    else if (want_ls && hs_gate_low)  state_nx = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (want_hs)       state_nx = ST_WAIT_LS_LOW;
                    else if (!want_ls) state_nx = ST_OFF;
                end
                ST_WAIT_LS_LOW: begin
                    if (!want_hs)                     state_nx = ST_OFF;
                    else if (dly_done[DLY_DEAD_ON])   state_nx = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (!want_hs) state_nx = ST_WAIT_SW_LOW;
                end
                ST_WAIT_SW_LOW: begin
                    if (want_hs)                      state_nx = ST_WAIT_LS_LOW;
                    else if (!want_ls)                state_nx = ST_OFF;
                    else if (dly_done[DLY_DEAD_OFF] || dly_done[DLY_TIMEOUT])
                                                      state_nx = ST_LS_ON;
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Enables decode a single phase each.
    always_comb begin
        hs_en = (state == ST_HS_ON);
        ls_en = (state == ST_LS_ON);
    end
endmodule

// File: rtl/gate_seq_checker.sv
// Port-level properties of the gate sequencer, bound to every instance.
// Assumes the synchronous active-low reset of the design.
module gate_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic pwm_tri,
    input logic drive_en,
    input logic supply_ok,
    input logic sync_mode,
    input logic ls_gate_low,
    input logic hs_en,
    input logic ls_en
);
    // R2: enables never overlap.
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R3: high side only rises after low side was off and sensed low.
    a_r3_hs_after_ls_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(ls_gate_low) && !$past(ls_en)));

    // R4: low side only rises after the high side was already off.
    a_r4_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    // R6: disable clears both enables at the next edge.
    a_r6_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (!hs_en && !ls_en));

    // R7: supply lockout clears both enables at the next edge.
    a_r7_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_en && !ls_en));

    // R8: idle window clears both enables at the next edge.
    a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_tri |=> (!hs_en && !ls_en));

    // R9: diode-emulation mode keeps the low side off.
    a_r9_skip_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !ls_en);
endmodule

bind deadtime_gate_seq gate_seq_checker i_gate_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_tri     (pwm_tri),
    .drive_en    (drive_en),
    .supply_ok   (supply_ok),
    .sync_mode   (sync_mode),
    .ls_gate_low (ls_gate_low),
    .hs_en       (hs_en),
    .ls_en       (ls_en)
);

// File: tb/test_deadtime_gate_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module test_deadtime_gate_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned DON  = 2;
    localparam int unsigned DOFF = 3;
    localparam int unsigned TMO  = 12;

    logic clk = 1'b0;
    logic rst_n, pwm_cmd, pwm_tri, drive_en, supply_ok, sync_mode;
    logic ls_gate_low, sw_node_low, hs_gate_low;
    logic hs_en, ls_en;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    deadtime_gate_seq #(.DEAD_ON_CYC(DON), .DEAD_OFF_CYC(DOFF), .TIMEOUT_CYC(TMO)) i_deadtime_gate_seq (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .pwm_tri(pwm_tri),
        .drive_en(drive_en), .supply_ok(supply_ok), .sync_mode(sync_mode),
        .ls_gate_low(ls_gate_low), .sw_node_low(sw_node_low), .hs_gate_low(hs_gate_low),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    // Advance one edge; inputs and samples both sit at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_en(input logic exp_hs, input logic exp_ls, input string req);
        checks++;
        if (hs_en !== exp_hs || ls_en !== exp_ls || (hs_en && ls_en)) begin
            errors++;
            $display("FAIL %s: hs_en=%b ls_en=%b expected hs_en=%b ls_en=%b (R2 overlap also checked)",
                     req, hs_en, ls_en, exp_hs, exp_ls);
        end
    endtask

    task automatic nominal();
        pwm_tri = 0; drive_en = 1; supply_ok = 1; sync_mode = 1;
    endtask

    task automatic go_ls_on();
        nominal(); pwm_cmd = 0; hs_gate_low = 1; ls_gate_low = 0; sw_node_low = 0;
        tick(); tick();
    endtask

    task automatic go_hs_on();
        go_ls_on();
        pwm_cmd = 1; ls_gate_low = 1;
        repeat (DON + 1) tick();
        ls_gate_low = 0; hs_gate_low = 0; sw_node_low = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; pwm_cmd = 1; nominal(); ls_gate_low = 1; sw_node_low = 1; hs_gate_low = 1;
        tick(); tick();
        expect_en(0, 0, "R1 reset");
        rst_n = 1;
    endtask

    task automatic t_rise();
        go_ls_on();
        expect_en(0, 1, "R3 start in low side");
        pwm_cmd = 1; ls_gate_low = 0;
        tick();
        expect_en(0, 0, "R3 low side off first");
        repeat (3) tick();
        expect_en(0, 0, "R3 no high side without sense");
        ls_gate_low = 1;
        repeat (DON - 1) tick();
        expect_en(0, 0, "R3 dead-on not yet elapsed");
        tick();
        expect_en(1, 0, "R3 high side after dead-on");
    endtask

    task automatic t_fall();
        go_hs_on();
        pwm_cmd = 0;
        tick();
        expect_en(0, 0, "R4 high side off first");
        repeat (3) tick();
        expect_en(0, 0, "R4 waiting for switch node");
        sw_node_low = 1;
        repeat (DOFF - 1) tick();
        expect_en(0, 0, "R4 dead-off not yet elapsed");
        tick();
        expect_en(0, 1, "R4 low side after dead-off");
    endtask

    task automatic t_timeout();
        go_hs_on();
        pwm_cmd = 0;
        tick();
        hs_gate_low = 1;
        repeat (TMO - 1) tick();
        expect_en(0, 0, "R5 timeout not yet elapsed");
        tick();
        expect_en(0, 1, "R5 low side after timeout");
    endtask

    task automatic t_disable();
        go_hs_on();
        drive_en = 0;
        tick();
        expect_en(0, 0, "R6 disable with pwm high");
        pwm_cmd = 0; hs_gate_low = 1;
        tick();
        expect_en(0, 0, "R6 disable with pwm low");
        drive_en = 1;
        tick();
        expect_en(0, 1, "R6 re-enable low side");
    endtask

    task automatic t_lockout();
        go_ls_on();
        supply_ok = 0;
        tick();
        expect_en(0, 0, "R7 lockout with pwm low");
        pwm_cmd = 1; ls_gate_low = 1;
        repeat (DON + 2) tick();
        expect_en(0, 0, "R7 lockout with pwm high");
    endtask

    task automatic t_idle();
        go_hs_on();
        pwm_tri = 1;
        tick();
        expect_en(0, 0, "R8 idle entry");
        repeat (3) tick();
        expect_en(0, 0, "R8 idle hold");
        pwm_tri = 0; pwm_cmd = 0; hs_gate_low = 1;
        tick();
        expect_en(0, 1, "R8 exit idle to low");
        pwm_tri = 1;
        tick();
        expect_en(0, 0, "R8 idle again");
        pwm_tri = 0; pwm_cmd = 1; ls_gate_low = 1;
        tick();
        repeat (DON - 1) tick();
        expect_en(0, 0, "R8 exit high before dead-on");
        tick();
        expect_en(1, 0, "R8 exit idle to high");
    endtask

    task automatic t_skip();
        go_ls_on();
        sync_mode = 0;
        tick();
        expect_en(0, 0, "R9 skip drops low side");
        pwm_cmd = 1; ls_gate_low = 1;
        tick();
        repeat (DON) tick();
        expect_en(1, 0, "R9 high side follows pwm");
        pwm_cmd = 0; sw_node_low = 1; hs_gate_low = 1;
        tick();
        expect_en(0, 0, "R9 high side off on pwm low");
        repeat (TMO + 2) tick();
        expect_en(0, 0, "R9 low side stays off");
        sync_mode = 1;
        tick();
        expect_en(0, 1, "R10 low side one cycle after sync returns");
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_timeout();
        t_disable();
        t_lockout();
        t_idle();
        t_skip();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule